// File: doc/BRIEF.md
# Directed-Mode Mantissa Rounder

This block takes a normalized mantissa whose two lowest bits are the guard and round bits, together with a separate sticky bit, the operand sign and a 2-bit rounding mode. It drops the guard and round bits and decides whether the remaining mantissa must be bumped by one unit in the last place. It returns the rounded mantissa, the carry out of the increment, a round-up indication and three exception flags: inexact, fraction-inexact and fraction-rounded.

The caller also reports whether the exponent of the value has already overflowed. The block then selects the overflow target, either infinity or the largest finite magnitude, and raises an overflow flag when infinity is chosen. The block does not renormalize after a carry out of the top bit, handle denormals or pack a result. All outputs are registered and appear one clock after the input is accepted.

Top module: `mant_round_unit`

## Requirements
- R1: After reset all outputs are zero. An input presented with `in_valid` high at a rising edge appears on the outputs right after that edge, with `out_valid` high.
- R2: When guard (`in_mant[1]`), round (`in_mant[0]`) and sticky are all zero, `out_mant` equals `in_mant` shifted right by two. `out_carry`, `out_round_up` and all exception flags are zero.
- R3: When any of guard, round or sticky is set, both `out_inexact` and `out_frac_inexact` are high.
- R4: In mode 00 (nearest), the unit rounds up only when guard is set and at least one of round, sticky or the least significant bit after the shift is set. An exact half therefore rounds to even.
- R5: In mode 01 (toward zero), the unit never rounds up.
- R6: Mode 10 (toward plus infinity) rounds an inexact value up only when the sign is 0. Mode 11 (toward minus infinity) rounds an inexact value up only when the sign is 1.
- R7: A round-up adds one to the shifted mantissa, and the carry ripples across the full width. A carry out of the top bit shows on `out_carry`. `out_frac_rounded` is high exactly when `out_round_up` is high.
- R8: With `in_ovf` high, `out_to_inf` is chosen in mode 00, never in mode 01, for sign 0 in mode 10 and for sign 1 in mode 11. Otherwise `out_to_max` is chosen. With `in_ovf` low, both are zero.
- R9: `out_ovf_flag` is high exactly when `out_to_inf` is high.
- R10: A cycle with `in_valid` low gives `out_valid` low and all flag outputs low, while `out_mant` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept the input this cycle |
| in_mant | input | MANT_W+2 | Mantissa; bit 1 is guard, bit 0 is round |
| in_sticky | input | 1 | OR of all bits below round |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_mode | input | 2 | 00 nearest, 01 zero, 10 plus inf, 11 minus inf |
| in_ovf | input | 1 | Caller reports exponent overflow |
| out_valid | output | 1 | Result valid |
| out_mant | output | MANT_W | Rounded mantissa without guard/round |
| out_carry | output | 1 | Carry out of the increment |
| out_round_up | output | 1 | An increment was applied |
| out_inexact | output | 1 | Inexact flag |
| out_frac_inexact | output | 1 | Fraction-inexact flag |
| out_frac_rounded | output | 1 | Fraction-rounded flag |
| out_ovf_flag | output | 1 | Overflow flag (target is infinity) |
| out_to_inf | output | 1 | Overflow target is infinity |
| out_to_max | output | 1 | Overflow target is largest finite magnitude |

## Verification
The hardest case to reach from the ports is a round-up that carries through every bit of the mantissa into `out_carry`. It needs an all-ones shifted mantissa together with a mode, sign and guard/round/sticky pattern that forces an increment. The stimulus builds that operand directly and repeats it with the carry stopped one bit short. The exact-half tie is the other hard case, and it is driven with both an even and an odd least significant bit so that round-to-even is seen in both directions.

// File: rtl/mant_round_pkg.sv
package mant_round_pkg;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_POS_INF = 2'b10,
    RM_NEG_INF = 2'b11
  } rmode_e;

  // Decide whether an inexact value must be bumped by one ulp.
  function automatic logic want_increment(input rmode_e mode, input logic sign,
                                          input logic g, input logic r,
                                          input logic s, input logic lsb);
    logic lost;
    lost = g | r | s;
    unique case (mode)
      RM_NEAREST: want_increment = g & (r | s | lsb);
      RM_ZERO:    want_increment = 1'b0;
      RM_POS_INF: want_increment = lost & ~sign;
      RM_NEG_INF: want_increment = lost & sign;
      default:    want_increment = 1'b0;
    endcase
  endfunction

  // Decide whether an overflowing result saturates to infinity.
  function automatic logic overflow_goes_inf(input rmode_e mode, input logic sign);
    unique case (mode)
      RM_NEAREST: overflow_goes_inf = 1'b1;
      RM_ZERO:    overflow_goes_inf = 1'b0;
      RM_POS_INF: overflow_goes_inf = ~sign;
      RM_NEG_INF: overflow_goes_inf = sign;
      default:    overflow_goes_inf = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
  import mant_round_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       sign,
  input  logic       guard_bit,
  input  logic       round_bit,
  input  logic       sticky_bit,
  input  logic       lsb,
  output logic       inexact,
  output logic       incr
);
  rmode_e mode_e;

  always_comb begin
    mode_e  = rmode_e'(mode);
    inexact = guard_bit | round_bit | sticky_bit;
    incr    = want_increment(mode_e, sign, guard_bit, round_bit, sticky_bit, lsb);
  end
endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
  parameter int W = 24
) (
  input  logic [W-1:0] base,
  input  logic         inc,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] cy;

  assign cy[0] = inc;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_ha
      assign sum[i]  = base[i] ^ cy[i];
      assign cy[i+1] = base[i] & cy[i];
    end
  endgenerate

  assign cout = cy[W];
endmodule

// File: rtl/rnd_ovf_sel.sv
module rnd_ovf_sel
  import mant_round_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       sign,
  input  logic       ovf,
  output logic       to_inf,
  output logic       to_max
);
  logic goes_inf;

  always_comb begin
    goes_inf = overflow_goes_inf(rmode_e'(mode), sign);
    to_inf   = ovf & goes_inf;
    to_max   = ovf & ~goes_inf;
  end
endmodule

// File: rtl/mant_round_unit.sv
module mant_round_unit #(
  parameter int MANT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [MANT_W+1:0] in_mant,
  input  logic              in_sticky,
  input  logic              in_sign,
  input  logic [1:0]        in_mode,
  input  logic              in_ovf,
  output logic              out_valid,
  output logic [MANT_W-1:0] out_mant,
  output logic              out_carry,
  output logic              out_round_up,
  output logic              out_inexact,
  output logic              out_frac_inexact,
  output logic              out_frac_rounded,
  output logic              out_ovf_flag,
  output logic              out_to_inf,
  output logic              out_to_max
);
  localparam int IN_W = MANT_W + 2;

  // Named internal events
  logic [MANT_W-1:0] shifted_mant;
  logic              g_bit, r_bit;
  logic              ev_inexact;
  logic              ev_incr;
  logic [MANT_W-1:0] rounded_mant;
  logic              ev_carry;
  logic              ev_to_inf;
  logic              ev_to_max;

  assign shifted_mant = in_mant[IN_W-1:2];
  assign g_bit        = in_mant[1];
  assign r_bit        = in_mant[0];

  rnd_decide u_decide (
    .mode       (in_mode),
    .sign       (in_sign),
    .guard_bit  (g_bit),
    .round_bit  (r_bit),
    .sticky_bit (in_sticky),
    .lsb        (shifted_mant[0]),
    .inexact    (ev_inexact),
    .incr       (ev_incr)
  );

  rnd_incr #(.W(MANT_W)) u_incr (
    .base (shifted_mant),
    .inc  (ev_incr),
    .sum  (rounded_mant),
    .cout (ev_carry)
  );

  rnd_ovf_sel u_ovf (
    .mode   (in_mode),
    .sign   (in_sign),
    .ovf    (in_ovf),
    .to_inf (ev_to_inf),
    .to_max (ev_to_max)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid        <= 1'b0;
      out_mant         <= '0;
      out_carry        <= 1'b0;
      out_round_up     <= 1'b0;
      out_inexact      <= 1'b0;
      out_frac_inexact <= 1'b0;
      out_frac_rounded <= 1'b0;
      out_ovf_flag     <= 1'b0;
      out_to_inf       <= 1'b0;
      out_to_max       <= 1'b0;
    end else begin
      out_valid        <= in_valid;
      out_carry        <= in_valid & ev_carry;
      out_round_up     <= in_valid & ev_incr;
      out_inexact      <= in_valid & ev_inexact;
      out_frac_inexact <= in_valid & ev_inexact;
      out_frac_rounded <= in_valid & ev_incr;
      out_ovf_flag     <= in_valid & ev_to_inf;
      out_to_inf       <= in_valid & ev_to_inf;
      out_to_max       <= in_valid & ev_to_max;
      if (in_valid) out_mant <= rounded_mant;
    end
  end

  // Assertions next to the logic they guard
  assert_exact_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mant[1:0] == 2'b00 && !in_sticky) |=>
      (!out_inexact && !out_round_up && !out_carry &&
       out_mant == $past(in_mant[IN_W-1:2])));

  assert_inexact_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_inexact |-> (out_frac_inexact && out_valid));

  assert_nearest_needs_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b00 && !in_mant[1]) |=> !out_round_up);

  assert_zero_no_bump_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b01) |=> !out_round_up);

  assert_directed_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ((in_mode == 2'b10 && in_sign) || (in_mode == 2'b11 && !in_sign)))
      |=> !out_round_up);

  assert_rounded_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_frac_rounded == out_round_up);

  assert_carry_needs_bump_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_carry |-> (out_round_up && out_mant == '0));

  assert_target_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_to_inf, out_to_max}));

  assert_zero_mode_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ovf && in_mode == 2'b01) |=> (out_to_max && !out_ovf_flag));

  assert_ovf_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_ovf_flag == out_to_inf);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_inexact && !out_round_up && !out_to_inf &&
                   !out_to_max && $stable(out_mant)));
endmodule

// File: tb/mant_round_unit_tb.sv
module mant_round_unit_tb;
  localparam int W = 24;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [W+1:0]   in_mant = '0;
  logic           in_sticky = 1'b0;
  logic           in_sign = 1'b0;
  logic [1:0]     in_mode = 2'b00;
  logic           in_ovf = 1'b0;
  logic           out_valid, out_carry, out_round_up, out_inexact;
  logic           out_frac_inexact, out_frac_rounded, out_ovf_flag;
  logic           out_to_inf, out_to_max;
  logic [W-1:0]   out_mant;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mant_round_unit #(.MANT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mant(in_mant),
    .in_sticky(in_sticky), .in_sign(in_sign), .in_mode(in_mode), .in_ovf(in_ovf),
    .out_valid(out_valid), .out_mant(out_mant), .out_carry(out_carry),
    .out_round_up(out_round_up), .out_inexact(out_inexact),
    .out_frac_inexact(out_frac_inexact), .out_frac_rounded(out_frac_rounded),
    .out_ovf_flag(out_ovf_flag), .out_to_inf(out_to_inf), .out_to_max(out_to_max)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Independent reference: compare the discarded fraction against one half.
  function automatic logic ref_up(input logic [1:0] mode, input logic sign,
                                  input logic [1:0] gr, input logic s, input logic lsb);
    logic nonzero;
    nonzero = (gr != 2'b00) || s;
    if (!nonzero) return 1'b0;
    case (mode)
      2'b00: begin
        if (gr[1] == 1'b0) return 1'b0;            // below half
        if (gr[0] || s)    return 1'b1;            // above half
        return lsb;                                // exact half: to even
      end
      2'b01: return 1'b0;
      2'b10: return (sign == 1'b0);
      default: return (sign == 1'b1);
    endcase
  endfunction

  // Drive one operand, then compare every output against the reference.
  task automatic apply(input string req, input logic [W+1:0] m, input logic s,
                       input logic sg, input logic [1:0] md, input logic ov);
    logic         up, inx, inf_exp, max_exp;
    logic [W:0]   sum;
    @(negedge clk);
    in_valid = 1'b1; in_mant = m; in_sticky = s; in_sign = sg; in_mode = md; in_ovf = ov;
    @(negedge clk);
    in_valid = 1'b0;
    up  = ref_up(md, sg, m[1:0], s, m[2]);
    inx = (m[1:0] != 2'b00) || s;
    sum = {1'b0, m[W+1:2]} + (W+1)'(up);
    inf_exp = ov && (md == 2'b00 || (md == 2'b10 && !sg) || (md == 2'b11 && sg));
    max_exp = ov && !inf_exp;
    chk({req, " R1 valid"}, 64'(out_valid), 64'd1);
    chk({req, " mant"}, 64'(out_mant), 64'(sum[W-1:0]));
    chk({req, " R7 carry"}, 64'(out_carry), 64'(sum[W]));
    chk({req, " roundup"}, 64'(out_round_up), 64'(up));
    chk({req, " R7 frac_rounded"}, 64'(out_frac_rounded), 64'(up));
    chk({req, " R3 inexact"}, 64'({out_inexact, out_frac_inexact}), 64'({inx, inx}));
    chk({req, " R8 target"}, 64'({out_to_inf, out_to_max}), 64'({inf_exp, max_exp}));
    chk({req, " R9 ovf_flag"}, 64'(out_ovf_flag), 64'(inf_exp));
  endtask

  task automatic t_reset();
    chk("R1 reset valid", 64'(out_valid), 64'd0);
    chk("R1 reset mant", 64'(out_mant), 64'd0);
    chk("R1 reset flags", 64'({out_carry, out_round_up, out_inexact, out_frac_inexact,
        out_frac_rounded, out_ovf_flag, out_to_inf, out_to_max}), 64'd0);
  endtask

  task automatic t_exact();
    for (int md = 0; md < 4; md++) begin
      apply("R2 exact", {24'hA5_5A_3C, 2'b00}, 1'b0, md[0], 2'(md), 1'b0);
      chk("R2 exact unchanged", 64'(out_mant), 64'h A55A3C);
    end
  endtask

  task automatic t_nearest();
    apply("R4 below half",   {24'h000010, 2'b01}, 1'b1, 1'b0, 2'b00, 1'b0);
    apply("R4 above half",   {24'h000010, 2'b11}, 1'b0, 1'b0, 2'b00, 1'b0);
    apply("R4 sticky above", {24'h000010, 2'b10}, 1'b1, 1'b1, 2'b00, 1'b0);
    apply("R4 tie even",     {24'h000010, 2'b10}, 1'b0, 1'b0, 2'b00, 1'b0);
    chk("R4 tie even stays", 64'(out_mant), 64'h10);
    apply("R4 tie odd",      {24'h000011, 2'b10}, 1'b0, 1'b1, 2'b00, 1'b0);
    chk("R4 tie odd to even", 64'(out_mant), 64'h12);
  endtask

  task automatic t_zero();
    apply("R5 zero pos", {24'h123457, 2'b11}, 1'b1, 1'b0, 2'b01, 1'b0);
    apply("R5 zero neg", {24'h123457, 2'b11}, 1'b1, 1'b1, 2'b01, 1'b0);
    chk("R5 zero truncates", 64'(out_mant), 64'h123457);
  endtask

  task automatic t_directed();
    apply("R6 plus pos",  {24'h000100, 2'b00}, 1'b1, 1'b0, 2'b10, 1'b0);
    chk("R6 plus pos bumps", 64'(out_mant), 64'h101);
    apply("R6 plus neg",  {24'h000100, 2'b01}, 1'b0, 1'b1, 2'b10, 1'b0);
    apply("R6 minus neg", {24'h000100, 2'b01}, 1'b0, 1'b1, 2'b11, 1'b0);
    chk("R6 minus neg bumps", 64'(out_mant), 64'h101);
    apply("R6 minus pos", {24'h000100, 2'b10}, 1'b0, 1'b0, 2'b11, 1'b0);
  endtask

  task automatic t_carry();
    apply("R7 full carry", {24'hFFFFFF, 2'b11}, 1'b0, 1'b0, 2'b00, 1'b0);
    chk("R7 full carry out", 64'({out_carry, out_mant}), 64'h1000000);
    apply("R7 near carry", {24'hFFFFFE, 2'b11}, 1'b0, 1'b0, 2'b00, 1'b0);
    chk("R7 near carry stops", 64'({out_carry, out_mant}), 64'hFFFFFF);
    apply("R7 mid carry", {24'h00FFFF, 2'b00}, 1'b1, 1'b1, 2'b11, 1'b0);
    chk("R7 mid carry ripple", 64'(out_mant), 64'h010000);
  endtask

  task automatic t_overflow();
    for (int md = 0; md < 4; md++)
      for (int sg = 0; sg < 2; sg++)
        apply("R8 overflow", {24'h7FFFFF, 2'b00}, 1'b0, sg[0], 2'(md), 1'b1);
  endtask

  task automatic t_idle();
    logic [W-1:0] held;
    apply("R10 prime", {24'h0ABCDE, 2'b11}, 1'b0, 1'b0, 2'b00, 1'b1);
    held = out_mant;
    @(negedge clk);
    in_mant = {24'h111111, 2'b11}; in_ovf = 1'b1; in_sticky = 1'b1;
    @(negedge clk);
    chk("R10 idle valid", 64'(out_valid), 64'd0);
    chk("R10 idle flags", 64'({out_round_up, out_inexact, out_frac_inexact,
        out_frac_rounded, out_ovf_flag, out_to_inf, out_to_max, out_carry}), 64'd0);
    chk("R10 idle mant held", 64'(out_mant), 64'(held));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_exact();
    t_nearest();
    t_zero();
    t_directed();
    t_carry();
    t_overflow();
    t_idle();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule